// File: doc/BRIEF.md
# Device Power State Controller

This block follows the power state of a network controller that sits on a shared system bus. It has three states. The uninitialized active state is entered after reset or on a return from low power. The fully active state is entered once memory decode is switched on. The low-power D3 state is entered and left only through writes to the power state field of a power management control/status register.

Configuration-space writes arrive as two plain strobes, one per register, over one shared data bus. The block answers with readback values for both registers. It also drives the control pins that the rest of the controller obeys: clock gate enables, memory and I/O decode enables, permission for bus-master cycles, permission for link frame transmission and link idle generation, and a full-power request to the physical layer.

A simple access-claim port tells the bus front end whether an access of a given kind would be accepted in the current state. `acc_valid` with `acc_kind` is presented and `acc_claim` answers in the same cycle, combinationally. The port never stalls, so there is no back-pressure on it. A held wake-enable bit stays armed across every state change.

Top module: `dev_pwr_ctrl`

## Requirements
- R1: A synchronous active-low reset gives `pwr_state` 2'b00 (uninitialized active), both readbacks all zero, all command enables cleared, `wake_armed` 0, `state_chg` 0, `clk_en` equal to KEEP_MASK, and `phy_full_pwr` 0.
- R2: A control/status write whose bits [1:0] equal 2'b11, made from either active state, gives `pwr_state` 2'b11 (D3) on the next cycle, and bits [1:0] of the control/status readback become 2'b11.
- R3: In the uninitialized active state, once command bit 1 (memory enable) is held set, `pwr_state` becomes 2'b01 (fully active) on the following cycle.
- R4: Entry to D3 clears command bits 1 (memory) and 0 (I/O), even when a command write in the same cycle sets them.
- R5: In D3, only accesses with `acc_kind` 2'b00 (configuration) are claimed. Kinds 2'b01 (memory) and 2'b10 (I/O) are refused even if their enable bits are set. Kind 2'b11 is never claimed.
- R6: In D3, `master_en` and `tx_en` are 0, and `idle_en` is 0 exactly when the wake enable is set.
- R7: A control/status write of 2'b00 in bits [1:0] while in D3 returns `pwr_state` to 2'b00 on the next cycle, never directly to 2'b01.
- R8: Control/status writes with bits [1:0] equal to 2'b01 or 2'b10 leave the power state and its readback unchanged.
- R9: Control/status bit 8 (wake enable) is written by every control/status write and holds its value across every state change. `wake_armed` and readback bit 8 show it.
- R10: In the fully active state, `clk_en` is all ones and `phy_full_pwr` is 1. In the other two states, `clk_en` equals KEEP_MASK and `phy_full_pwr` is 0.
- R11: `state_chg` is 1 for exactly the first cycle spent in each new state, and 0 in all other cycles.
- R12: Outside D3, memory and I/O accesses are claimed when command bits 1 and 0 are set. `master_en` follows command bit 2. `tx_en` is 1 only in the fully active state, and `idle_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_pmcsr | input | 1 | Write strobe, power management control/status register |
| cfg_wr_cmd | input | 1 | Write strobe, command register |
| cfg_wdata | input | REG_W | Shared configuration write data |
| acc_valid | input | 1 | An access is being offered |
| acc_kind | input | 2 | 00 config, 01 memory, 10 I/O |
| acc_claim | output | 1 | Offered access is accepted |
| pmcsr_rdata | output | REG_W | Control/status readback |
| cmd_rdata | output | REG_W | Command readback |
| pwr_state | output | 2 | 00 uninit active, 01 fully active, 11 D3 |
| state_chg | output | 1 | One-cycle pulse on entering a new state |
| clk_en | output | NUM_CLK | Internal clock gate enables |
| mem_dec_en | output | 1 | Memory decode enable |
| io_dec_en | output | 1 | I/O decode enable |
| master_en | output | 1 | Bus-master cycles permitted |
| tx_en | output | 1 | Link frame transmission permitted |
| idle_en | output | 1 | Link idle generation permitted |
| phy_full_pwr | output | 1 | Full-power request to the physical layer |
| wake_armed | output | 1 | Wake enable held |

## Verification
The bench builds the block with NUM_CLK set to 6 and KEEP_MASK set to 6'b000101. With these values the reduced clock set differs from both all-ones and all-zeros, so a wrong mask or a missed gate in any state is visible at the pins. The default bit positions are kept, so the bench can reach the same-cycle collision of a command write with a D3 entry that shares its data word. It also reaches a return from D3 with memory enable set, which must go through the uninitialized state first.

// File: rtl/dpsc_pkg.sv
package dpsc_pkg;
  typedef enum logic [1:0] {
    ST_D0U = 2'b00,
    ST_D0A = 2'b01,
    ST_D3  = 2'b11
  } pstate_e;

  // Power state field codes in the control/status register
  localparam logic [1:0] PSF_D0 = 2'b00;
  localparam logic [1:0] PSF_D3 = 2'b11;

  // Access kinds on the claim port
  localparam logic [1:0] ACC_CFG = 2'b00;
  localparam logic [1:0] ACC_MEM = 2'b01;
  localparam logic [1:0] ACC_IO  = 2'b10;
endpackage

// File: rtl/dpsc_cfg_regs.sv
module dpsc_cfg_regs #(
  parameter int REG_W   = 16,
  parameter int IO_BIT  = 0,
  parameter int MEM_BIT = 1,
  parameter int BM_BIT  = 2,
  parameter int PME_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pmcsr,
  input  logic             wr_cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             clr_decode,
  output logic [REG_W-1:0] cmd_q,
  output logic             pme_en
);
  localparam logic [REG_W-1:0] ONE       = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] DEC_MASK  = (ONE << IO_BIT) | (ONE << MEM_BIT);
  localparam logic [REG_W-1:0] CMD_WMASK = DEC_MASK | (ONE << BM_BIT);

  logic [REG_W-1:0] cmd_nxt;

  // Decode clear on D3 entry takes priority over a same-cycle command write
  always_comb begin
    cmd_nxt = cmd_q;
    if (wr_cmd)     cmd_nxt = wdata & CMD_WMASK;
    if (clr_decode) cmd_nxt = cmd_nxt & ~DEC_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      pme_en <= 1'b0;
    end else begin
      cmd_q <= cmd_nxt;
      if (wr_pmcsr) pme_en <= wdata[PME_BIT];
    end
  end
endmodule

// File: rtl/dpsc_fsm.sv
module dpsc_fsm
  import dpsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps_wr,
  input  logic [1:0] ps_code,
  input  logic       mem_en,
  output pstate_e    state,
  output logic       d3_entry,
  output logic       state_chg
);
  pstate_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_D0U: begin
        if (ps_wr && ps_code == PSF_D3) nxt = ST_D3;
        else if (mem_en)                nxt = ST_D0A;
      end
      ST_D0A: begin
        if (ps_wr && ps_code == PSF_D3) nxt = ST_D3;
      end
      ST_D3: begin
        if (ps_wr && ps_code == PSF_D0) nxt = ST_D0U;
      end
      default: nxt = ST_D0U;
    endcase
  end

  assign d3_entry = (nxt == ST_D3) && (state != ST_D3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_D0U;
      state_chg <= 1'b0;
    end else begin
      state     <= nxt;
      state_chg <= (nxt != state);
    end
  end
endmodule

// File: rtl/dpsc_gate.sv
module dpsc_gate
  import dpsc_pkg::*;
#(
  parameter int                 REG_W     = 16,
  parameter int                 IO_BIT    = 0,
  parameter int                 MEM_BIT   = 1,
  parameter int                 BM_BIT    = 2,
  parameter int                 PME_BIT   = 8,
  parameter int                 NUM_CLK   = 8,
  parameter logic [NUM_CLK-1:0] KEEP_MASK = 8'h03
) (
  input  pstate_e              state,
  input  logic [REG_W-1:0]     cmd_q,
  input  logic                 pme_en,
  input  logic                 acc_valid,
  input  logic [1:0]           acc_kind,
  output logic                 acc_claim,
  output logic [REG_W-1:0]     pmcsr_rdata,
  output logic [NUM_CLK-1:0]   clk_en,
  output logic                 mem_dec_en,
  output logic                 io_dec_en,
  output logic                 master_en,
  output logic                 tx_en,
  output logic                 idle_en,
  output logic                 phy_full_pwr
);
  logic in_d3, active;

  assign in_d3  = (state == ST_D3);
  assign active = (state == ST_D0A);

  assign mem_dec_en   = cmd_q[MEM_BIT] && !in_d3;
  assign io_dec_en    = cmd_q[IO_BIT]  && !in_d3;
  assign master_en    = cmd_q[BM_BIT]  && !in_d3;
  assign tx_en        = active;
  assign idle_en      = !(in_d3 && pme_en);
  assign phy_full_pwr = active;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    assign clk_en[g] = active || KEEP_MASK[g];
  end

  always_comb begin
    acc_claim = 1'b0;
    if (acc_valid) begin
      case (acc_kind)
        ACC_CFG: acc_claim = 1'b1;
        ACC_MEM: acc_claim = mem_dec_en;
        ACC_IO:  acc_claim = io_dec_en;
        default: acc_claim = 1'b0;
      endcase
    end
  end

  always_comb begin
    pmcsr_rdata          = '0;
    pmcsr_rdata[1:0]     = in_d3 ? PSF_D3 : PSF_D0;
    pmcsr_rdata[PME_BIT] = pme_en;
  end
endmodule

// File: rtl/dev_pwr_ctrl.sv
module dev_pwr_ctrl
  import dpsc_pkg::*;
#(
  parameter int                 REG_W     = 16,
  parameter int                 IO_BIT    = 0,
  parameter int                 MEM_BIT   = 1,
  parameter int                 BM_BIT    = 2,
  parameter int                 PME_BIT   = 8,
  parameter int                 NUM_CLK   = 8,
  parameter logic [NUM_CLK-1:0] KEEP_MASK = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_pmcsr,
  input  logic               cfg_wr_cmd,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               acc_valid,
  input  logic [1:0]         acc_kind,
  output logic               acc_claim,
  output logic [REG_W-1:0]   pmcsr_rdata,
  output logic [REG_W-1:0]   cmd_rdata,
  output logic [1:0]         pwr_state,
  output logic               state_chg,
  output logic [NUM_CLK-1:0] clk_en,
  output logic               mem_dec_en,
  output logic               io_dec_en,
  output logic               master_en,
  output logic               tx_en,
  output logic               idle_en,
  output logic               phy_full_pwr,
  output logic               wake_armed
);
  pstate_e          state;
  logic             d3_entry;
  logic [REG_W-1:0] cmd_q;
  logic             pme_en;

  dpsc_cfg_regs #(
    .REG_W(REG_W), .IO_BIT(IO_BIT), .MEM_BIT(MEM_BIT),
    .BM_BIT(BM_BIT), .PME_BIT(PME_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pmcsr(cfg_wr_pmcsr), .wr_cmd(cfg_wr_cmd), .wdata(cfg_wdata),
    .clr_decode(d3_entry), .cmd_q(cmd_q), .pme_en(pme_en)
  );

  dpsc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ps_wr(cfg_wr_pmcsr), .ps_code(cfg_wdata[1:0]),
    .mem_en(cmd_q[MEM_BIT]),
    .state(state), .d3_entry(d3_entry), .state_chg(state_chg)
  );

  dpsc_gate #(
    .REG_W(REG_W), .IO_BIT(IO_BIT), .MEM_BIT(MEM_BIT), .BM_BIT(BM_BIT),
    .PME_BIT(PME_BIT), .NUM_CLK(NUM_CLK), .KEEP_MASK(KEEP_MASK)
  ) u_gate (
    .state(state), .cmd_q(cmd_q), .pme_en(pme_en),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_claim(acc_claim),
    .pmcsr_rdata(pmcsr_rdata), .clk_en(clk_en),
    .mem_dec_en(mem_dec_en), .io_dec_en(io_dec_en), .master_en(master_en),
    .tx_en(tx_en), .idle_en(idle_en), .phy_full_pwr(phy_full_pwr)
  );

  assign cmd_rdata  = cmd_q;
  assign pwr_state  = state;
  assign wake_armed = pme_en;
endmodule

// File: rtl/dpsc_chk.sv
module dpsc_chk #(
  parameter int NUM_CLK = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_pmcsr,
  input logic [1:0]         ps_code,
  input logic               acc_valid,
  input logic [1:0]         acc_kind,
  input logic               acc_claim,
  input logic [1:0]         ps_rd,
  input logic               mem_rd,
  input logic               io_rd,
  input logic [1:0]         pwr_state,
  input logic               state_chg,
  input logic [NUM_CLK-1:0] clk_en,
  input logic               phy_full_pwr,
  input logic               master_en,
  input logic               tx_en,
  input logic               wake_armed
);
  p_enter_d3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b11) && wr_pmcsr && ps_code == 2'b11 |=> pwr_state == 2'b11 && ps_rd == 2'b11);

  p_entry_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b11) && wr_pmcsr && ps_code == 2'b11 |=> !mem_rd && !io_rd);

  p_cfg_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b11 && acc_valid && acc_kind != 2'b00 |-> !acc_claim);

  p_d3_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b11 |-> !master_en && !tx_en);

  p_exit_d0u_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b11 && wr_pmcsr && ps_code == 2'b00 |=> pwr_state == 2'b00);

  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pmcsr && (ps_code == 2'b01 || ps_code == 2'b10) |=> $stable(ps_rd));

  p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pmcsr |=> $stable(wake_armed));

  p_full_clocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b01 |-> clk_en == {NUM_CLK{1'b1}} && phy_full_pwr);

  p_chg_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg == (pwr_state != $past(pwr_state)));
endmodule

bind dev_pwr_ctrl dpsc_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_pmcsr(cfg_wr_pmcsr), .ps_code(cfg_wdata[1:0]),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_claim(acc_claim),
  .ps_rd(pmcsr_rdata[1:0]), .mem_rd(cmd_rdata[MEM_BIT]), .io_rd(cmd_rdata[IO_BIT]),
  .pwr_state(pwr_state), .state_chg(state_chg), .clk_en(clk_en),
  .phy_full_pwr(phy_full_pwr), .master_en(master_en), .tx_en(tx_en),
  .wake_armed(wake_armed)
);

// File: tb/tb_dev_pwr_ctrl.sv
module tb_dev_pwr_ctrl;
  localparam int              NCLK = 6;
  localparam logic [NCLK-1:0] KEEP = 6'b000101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, wc = 1'b0;
  logic [15:0] wd = '0;
  logic av = 1'b0;
  logic [1:0] ak = 2'b00;
  logic claim, chg, mde, ide, men, txe, ide2, phy, wake;
  logic [15:0] prd, crd;
  logic [1:0] pst;
  logic [NCLK-1:0] cke;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dev_pwr_ctrl #(.NUM_CLK(NCLK), .KEEP_MASK(KEEP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_pmcsr(wp), .cfg_wr_cmd(wc), .cfg_wdata(wd),
    .acc_valid(av), .acc_kind(ak), .acc_claim(claim),
    .pmcsr_rdata(prd), .cmd_rdata(crd), .pwr_state(pst), .state_chg(chg),
    .clk_en(cke), .mem_dec_en(mde), .io_dec_en(ide), .master_en(men),
    .tx_en(txe), .idle_en(ide2), .phy_full_pwr(phy), .wake_armed(wake)
  );

  typedef struct packed {
    logic       do_p;
    logic       do_c;
    logic [15:0] data;
    logic [1:0] st;
    logic       ch;
    logic [2:0] cmd;
    logic       pme;
  } vec_t;

  // Each row: strobes and data for one cycle, then state seen one cycle later
  localparam vec_t VECS [0:14] = '{
    '{1'b0, 1'b1, 16'h0001, 2'b00, 1'b0, 3'b001, 1'b0}, // R12 io only
    '{1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 3'b001, 1'b0}, // R3 no mem, stays
    '{1'b0, 1'b1, 16'h0007, 2'b00, 1'b0, 3'b111, 1'b0}, // R3 mem set
    '{1'b0, 1'b0, 16'h0000, 2'b01, 1'b1, 3'b111, 1'b0}, // R3 R11 to D0a
    '{1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 3'b111, 1'b0}, // R11 no pulse
    '{1'b1, 1'b0, 16'h0100, 2'b01, 1'b0, 3'b111, 1'b1}, // R9 wake on
    '{1'b1, 1'b0, 16'h0102, 2'b01, 1'b0, 3'b111, 1'b1}, // R8 code 10
    '{1'b1, 1'b0, 16'h0103, 2'b11, 1'b1, 3'b100, 1'b1}, // R2 R4 to D3
    '{1'b0, 1'b1, 16'h0003, 2'b11, 1'b0, 3'b011, 1'b1}, // cmd write in D3
    '{1'b1, 1'b0, 16'h0101, 2'b11, 1'b0, 3'b011, 1'b1}, // R8 code 01
    '{1'b1, 1'b0, 16'h0100, 2'b00, 1'b1, 3'b011, 1'b1}, // R7 to D0u
    '{1'b0, 1'b0, 16'h0000, 2'b01, 1'b1, 3'b011, 1'b1}, // R7 then D0a
    '{1'b1, 1'b0, 16'h0003, 2'b11, 1'b1, 3'b000, 1'b0}, // R2 R4 R9
    '{1'b1, 1'b0, 16'h0000, 2'b00, 1'b1, 3'b000, 1'b0}, // R7
    '{1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 3'b000, 1'b0}  // R11
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Called at a falling edge; strobes cover one rising edge, result sampled at the next falling edge
  task automatic cyc(input logic p, input logic c, input logic [15:0] d);
    wp = p; wc = c; wd = d;
    @(negedge clk);
    wp = 1'b0; wc = 1'b0; wd = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic claim_of(input logic [1:0] k);
    return 1'b0;
  endfunction

  task automatic probe(input logic [1:0] k, input logic exp, input string what);
    av = 1'b1; ak = k;
    #1;
    chk(what, {31'b0, claim}, {31'b0, exp});
    av = 1'b0; ak = 2'b00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr_state", {30'b0, pst}, 32'h0);
    chk("R1 state_chg", {31'b0, chg}, 32'h0);
    chk("R1 pmcsr", {16'b0, prd}, 32'h0);
    chk("R1 cmd", {16'b0, crd}, 32'h0);
    chk("R1 wake", {31'b0, wake}, 32'h0);
    chk("R1 clk_en", {26'b0, cke}, {26'b0, KEEP});
    chk("R1 phy", {31'b0, phy}, 32'h0);
    chk("R1 tx_en", {31'b0, txe}, 32'h0);
    chk("R1 idle_en", {31'b0, ide2}, 32'h1);

    // Vector walk (R2 R3 R4 R7 R8 R9 R11 R12)
    for (int i = 0; i < 15; i++) begin
      cyc(VECS[i].do_p, VECS[i].do_c, VECS[i].data);
      chk($sformatf("R2/R3/R7/R8 state v%0d", i), {30'b0, pst}, {30'b0, VECS[i].st});
      chk($sformatf("R11 pulse v%0d", i), {31'b0, chg}, {31'b0, VECS[i].ch});
      chk($sformatf("R4 cmd v%0d", i), {29'b0, crd[2:0]}, {29'b0, VECS[i].cmd});
      chk($sformatf("R9 wake v%0d", i), {31'b0, wake}, {31'b0, VECS[i].pme});
      chk($sformatf("R2 ps field v%0d", i), {30'b0, prd[1:0]}, {30'b0, VECS[i].st == 2'b11 ? 2'b11 : 2'b00});
    end

    // Fully active outputs (R10 R12)
    do_reset();
    cyc(1'b0, 1'b1, 16'h0007);
    @(negedge clk);
    chk("R3 active", {30'b0, pst}, 32'h1);
    chk("R10 clk_en full", {26'b0, cke}, 32'h3F);
    chk("R10 phy", {31'b0, phy}, 32'h1);
    chk("R12 tx_en", {31'b0, txe}, 32'h1);
    chk("R12 master_en", {31'b0, men}, 32'h1);
    chk("R12 idle_en", {31'b0, ide2}, 32'h1);
    probe(2'b00, 1'b1, "R12 cfg claim");
    probe(2'b01, 1'b1, "R12 mem claim");
    probe(2'b10, 1'b1, "R12 io claim");
    probe(2'b11, 1'b0, "R5 kind 11 refused");

    cyc(1'b0, 1'b1, 16'h0001);
    chk("R12 stays active", {30'b0, pst}, 32'h1);
    probe(2'b01, 1'b0, "R12 mem off");
    probe(2'b10, 1'b1, "R12 io on");
    chk("R12 master off", {31'b0, men}, 32'h0);

    // Same-cycle command write and D3 entry (R4)
    cyc(1'b1, 1'b1, 16'h0103);
    chk("R2 in D3", {30'b0, pst}, 32'h3);
    chk("R4 clear wins", {16'b0, crd}, 32'h0);
    chk("R2 pmcsr", {16'b0, prd}, 32'h0103);
    chk("R9 wake kept", {31'b0, wake}, 32'h1);
    probe(2'b00, 1'b1, "R5 cfg in D3");
    probe(2'b01, 1'b0, "R5 mem in D3");
    probe(2'b10, 1'b0, "R5 io in D3");
    chk("R6 master", {31'b0, men}, 32'h0);
    chk("R6 tx", {31'b0, txe}, 32'h0);
    chk("R6 idle with wake", {31'b0, ide2}, 32'h0);
    chk("R10 clk_en keep", {26'b0, cke}, {26'b0, KEEP});
    chk("R10 phy off", {31'b0, phy}, 32'h0);

    cyc(1'b0, 1'b1, 16'h0007);
    chk("R5 cmd stored", {16'b0, crd}, 32'h0007);
    probe(2'b01, 1'b0, "R5 mem gated");
    probe(2'b10, 1'b0, "R5 io gated");
    chk("R6 master gated", {31'b0, men}, 32'h0);

    cyc(1'b1, 1'b0, 16'h0003);
    chk("R6 still D3", {30'b0, pst}, 32'h3);
    chk("R11 no pulse", {31'b0, chg}, 32'h0);
    chk("R9 wake off", {31'b0, wake}, 32'h0);
    chk("R6 idle no wake", {31'b0, ide2}, 32'h1);

    // Reset while in D3 (R1)
    do_reset();
    @(negedge clk);
    chk("R1 reset from D3", {30'b0, pst}, 32'h0);
    chk("R1 cmd cleared", {16'b0, crd}, 32'h0);
    chk("R1 pmcsr cleared", {16'b0, prd}, 32'h0);
    chk("R1 phy", {31'b0, phy}, {31'b0, claim_of(2'b00)});

    finish_run();
  end
endmodule